// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block produces the 16x oversampling tick that a UART's transmit and receive shifters run on, from one peripheral clock. A bit time is made of sixteen sub-periods. Each sub-period lasts `divider + 1` clocks. A sub-period whose bit in a 16-bit stretch mask is set lasts one clock longer. Over a whole bit time this adds between 0 and 15 extra clocks, which gives the divisor a resolution of 1/16 of a sub-period.

Software sets `divider` to `(f_clk / f_baud) / 16 - 1`. The remainder `(f_clk / f_baud) mod 16` sets the stretch count. The stretch pattern comes from one of two places. It can be given directly on `stretch_mask`. It can also come from a built-in table indexed by `frac_sel`, which spreads the stretched sub-periods across the bit time instead of bunching them at one end.

Each tick marks the last clock of a sub-period. `sub_idx` reports which sub-period that tick ends.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high, and starting at the clock edge after `en` is sampled low, `tick` is 0 and `sub_idx` is 0.
- R2: Sub-period k (k = 0..15) lasts `divider + 1 + stretch[k]` clocks, where `stretch` is the selected 16-bit mask and bit k belongs to sub-period k.
- R3: Consecutive ticks carry `sub_idx` values 0, 1, ..., 15 and then wrap to 0, so a bit time contains 16 ticks.
- R4: The 16 sub-periods of one bit time add up to `16*divider + 16 + popcount(stretch)` clocks.
- R5: In table mode the mask is chosen by `frac_sel` as follows: 0 gives 0x0000, 1 gives 0x0080, 2 gives 0x0808, 3 gives 0x0888, 4 gives 0x2222, 5 gives 0x4924, 6 gives 0x4A52, 7 gives 0x54AA, 8 gives 0x5555, 9 gives 0xD555, 10 gives 0xD5D5, 11 gives 0xDDD5, 12 gives 0xDDDD, 13 gives 0xDFDD, 14 gives 0xDFDF, 15 gives 0xFFDF. The number of set bits always equals `frac_sel`.
- R6: With `use_table` = 0 the mask is `stretch_mask` and `frac_sel` has no effect. With `use_table` = 1 the mask is the table entry and `stretch_mask` has no effect.
- R7: `divider` and the mask are sampled only when a sub-period starts. A change in the middle of a sub-period leaves that sub-period's length unchanged and applies from the next one.
- R8: With `divider` = 0, an unstretched sub-period is 1 clock long, so ticks can occur on consecutive clocks. A stretched sub-period is 2 clocks long.
- R9: When `en` rises, the first sub-period is index 0. Its length is counted from the first clock edge at which `en` is sampled high, so the first tick arrives `divider + 1 + stretch[0]` clocks after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears the counters |
| divider | input | DIV_W (16) | Sub-period length minus one |
| stretch_mask | input | 16 | Direct stretch mask, bit k stretches sub-period k |
| frac_sel | input | 4 | Stretch count used to index the built-in table |
| use_table | input | 1 | 1: mask from table, 0: mask from `stretch_mask` |
| tick | output | 1 | One-clock pulse on the last clock of each sub-period |
| sub_idx | output | 4 | Index of the sub-period that is in progress or being ended |

## Verification
The checker assumes `rst` is high from time zero until the configuration inputs are defined. It does not assume that `divider`, the mask inputs or `use_table` are stable. It assumes only that they are known values, because the latched-length property is written to hold under arbitrary changes. The stimulus changes inputs only on falling clock edges, keeps `divider` small so that a full bit time stays short, and changes configuration in the middle of a sub-period on purpose only in the R7 scenario.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  localparam int unsigned SLOTS = 16;
  localparam int unsigned IDX_W = $clog2(SLOTS);

  typedef logic [SLOTS-1:0] slot_mask_t;
  typedef logic [IDX_W-1:0] slot_idx_t;

  // Evenly spread stretch pattern for a given stretch count.
  function automatic slot_mask_t spread_pattern(input logic [IDX_W-1:0] n);
    slot_mask_t p;
    case (n)
      4'd0:    p = 16'h0000;
      4'd1:    p = 16'h0080;
      4'd2:    p = 16'h0808;
      4'd3:    p = 16'h0888;
      4'd4:    p = 16'h2222;
      4'd5:    p = 16'h4924;
      4'd6:    p = 16'h4A52;
      4'd7:    p = 16'h54AA;
      4'd8:    p = 16'h5555;
      4'd9:    p = 16'hD555;
      4'd10:   p = 16'hD5D5;
      4'd11:   p = 16'hDDD5;
      4'd12:   p = 16'hDDDD;
      4'd13:   p = 16'hDFDD;
      4'd14:   p = 16'hDFDF;
      default: p = 16'hFFDF;
    endcase
    return p;
  endfunction

  // Last count value of a sub-period: divider plus one if stretched.
  function automatic logic [16:0] last_count(input logic [15:0] div, input logic stretch);
    return {1'b0, div} + {16'd0, stretch};
  endfunction

endpackage

// File: rtl/bg_pattern_rom.sv
module bg_pattern_rom
  import baudgen_pkg::*;
(
  input  logic [IDX_W-1:0] frac_sel,
  output slot_mask_t       pattern
);
  always_comb pattern = spread_pattern(frac_sel);
endmodule

// File: rtl/bg_mask_select.sv
module bg_mask_select
  import baudgen_pkg::*;
(
  input  logic       use_table,
  input  slot_mask_t reg_mask,
  input  slot_mask_t table_mask,
  output slot_mask_t mask_sel
);
  always_comb mask_sel = use_table ? table_mask : reg_mask;
endmodule

// File: rtl/bg_subperiod_ctr.sv
module bg_subperiod_ctr
  import baudgen_pkg::*;
#(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] divider,
  input  slot_mask_t       mask_sel,
  output logic             tick,
  output slot_idx_t        sub_idx,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] limit_o
);
  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit_m1;
  slot_idx_t        idx;
  slot_idx_t        idx_next;
  logic             at_end;

  always_comb begin
    idx_next = idx + 1'b1;
    at_end   = armed && (cnt == limit_m1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      armed    <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      limit_m1 <= '0;
    end else if (!armed) begin
      armed    <= 1'b1;
      cnt      <= '0;
      idx      <= '0;
      limit_m1 <= CNT_W'(last_count(16'(divider), mask_sel[0]));
    end else if (at_end) begin
      cnt      <= '0;
      idx      <= idx_next;
      limit_m1 <= CNT_W'(last_count(16'(divider), mask_sel[idx_next]));
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick    = at_end;
  assign sub_idx = idx;
  assign armed_o = armed;
  assign cnt_o   = cnt;
  assign limit_o = limit_m1;
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baudgen_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] divider,
  input  logic [15:0]      stretch_mask,
  input  logic [3:0]       frac_sel,
  input  logic             use_table,
  output logic             tick,
  output logic [3:0]       sub_idx
);
  localparam int unsigned CNT_W = DIV_W + 1;

  slot_mask_t       table_mask;
  slot_mask_t       mask_sel;
  logic             armed_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] limit_w;

  bg_pattern_rom u_rom (
    .frac_sel (frac_sel),
    .pattern  (table_mask)
  );

  bg_mask_select u_sel (
    .use_table  (use_table),
    .reg_mask   (stretch_mask),
    .table_mask (table_mask),
    .mask_sel   (mask_sel)
  );

  bg_subperiod_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .divider  (divider),
    .mask_sel (mask_sel),
    .tick     (tick),
    .sub_idx  (sub_idx),
    .armed_o  (armed_w),
    .cnt_o    (cnt_w),
    .limit_o  (limit_w)
  );
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk #(
  parameter int unsigned DIV_W = 16,
  localparam int unsigned CNT_W = DIV_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             use_table,
  input logic [3:0]       frac_sel,
  input logic [15:0]      table_mask,
  input logic             tick,
  input logic [3:0]       sub_idx,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] limit_m1
);
  // R1
  idle_after_disable_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> (!tick && sub_idx == 4'd0));

  // R3
  idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && en) |=> (sub_idx == $past(sub_idx) + 4'd1));

  // R7
  length_held_chk: assert property (@(posedge clk) disable iff (rst)
    (en && armed && !tick) |=> $stable(limit_m1));

  // R2
  count_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt <= limit_m1));

  // R5
  table_weight_chk: assert property (@(posedge clk) disable iff (rst)
    use_table |-> ($countones(table_mask) == int'(frac_sel)));
endmodule

bind baud_tick_gen baud_tick_gen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .use_table  (use_table),
  .frac_sel   (frac_sel),
  .table_mask (table_mask),
  .tick       (tick),
  .sub_idx    (sub_idx),
  .armed      (armed_w),
  .cnt        (cnt_w),
  .limit_m1   (limit_w)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [15:0] divider = '0;
  logic [15:0] stretch_mask = '0;
  logic [3:0]  frac_sel = '0;
  logic        use_table = 1'b0;
  logic        tick;
  logic [3:0]  sub_idx;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] spread [16] = '{16'h0000, 16'h0080, 16'h0808, 16'h0888,
                               16'h2222, 16'h4924, 16'h4A52, 16'h54AA,
                               16'h5555, 16'hD555, 16'hD5D5, 16'hDDD5,
                               16'hDDDD, 16'hDFDD, 16'hDFDF, 16'hFFDF};

  always #5 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst(rst), .en(en), .divider(divider),
    .stretch_mask(stretch_mask), .frac_sel(frac_sel), .use_table(use_table),
    .tick(tick), .sub_idx(sub_idx)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick && gap < 5000);
  endtask

  task automatic start(input logic [15:0] d, input logic [15:0] m,
                       input logic ut, input logic [3:0] f);
    @(negedge clk);
    divider = d; stretch_mask = m; use_table = ut; frac_sel = f;
    en = 1'b1;
  endtask

  task automatic stop_and_check_idle();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!tick && sub_idx == 4'd0, "R1 idle after disable", {tick, sub_idx}, 0);
  endtask

  // Measures one full bit time right after start(); expected mask m.
  task automatic measure_bit(input logic [15:0] d, input logic [15:0] m, input string req);
    int gap;
    int total = 0;
    for (int k = 0; k < 16; k++) begin
      wait_tick(gap);
      check(gap == int'(d) + 1 + int'(m[k]), {"R2 ", req}, gap, int'(d) + 1 + int'(m[k]));
      check(sub_idx == 4'(k), "R3 index order", sub_idx, k);
      total += gap;
    end
    check(total == 16 * int'(d) + 16 + $countones(m), {"R4 ", req}, total,
          16 * int'(d) + 16 + $countones(m));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(!tick && sub_idx == 4'd0, "R1 reset state", {tick, sub_idx}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!tick && sub_idx == 4'd0, "R1 enable low", {tick, sub_idx}, 0);
  endtask

  task automatic t_register_mode();
    start(16'd3, 16'h8001, 1'b0, 4'd9);
    measure_bit(16'd3, 16'h8001, "R6 reg mask ignores frac");
    stop_and_check_idle();
    start(16'd10, 16'h5A5A, 1'b0, 4'd0);
    measure_bit(16'd10, 16'h5A5A, "reg mask 5A5A");
    stop_and_check_idle();
  endtask

  task automatic t_table_mode();
    foreach (spread[f]) begin
      start(16'd2, 16'hFFFF, 1'b1, 4'(f));
      measure_bit(16'd2, spread[f], "R5 table entry, R6 reg mask ignored");
      stop_and_check_idle();
    end
  endtask

  task automatic t_zero_divider();
    start(16'd0, 16'h0001, 1'b0, 4'd0);
    measure_bit(16'd0, 16'h0001, "R8 divider zero");
    stop_and_check_idle();
  endtask

  task automatic t_mid_change();
    int gap;
    start(16'd5, 16'h0000, 1'b0, 4'd0);
    wait_tick(gap);
    check(gap == 6, "R9 first sub-period", gap, 6);
    repeat (2) @(negedge clk);
    divider = 16'd2;
    stretch_mask = 16'hFFFF;
    wait_tick(gap);
    check(gap + 2 == 6, "R7 current sub-period kept", gap + 2, 6);
    wait_tick(gap);
    check(gap == 4, "R7 new settings next sub-period", gap, 4);
    stop_and_check_idle();
  endtask

  task automatic t_restart();
    int gap;
    start(16'd4, 16'h0000, 1'b0, 4'd0);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(!tick && sub_idx == 4'd0, "R1 disable mid sub-period", {tick, sub_idx}, 0);
    en = 1'b1;
    wait_tick(gap);
    check(gap == 5 && sub_idx == 4'd0, "R9 restart at index 0", {gap, sub_idx}, {32'd5, 4'd0});
    stop_and_check_idle();
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_register_mode();
    t_table_mode();
    t_zero_divider();
    t_mid_change();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule